// File: doc/BRIEF.md
# Serial-Data-to-FIFO Channel Mapper

This block sits between the serial audio receivers and the channel FIFOs of an audio path. Each of up to four serial data inputs delivers decoded stereo pairs (a left and a right sample with a valid strobe). A small mapping table with one entry per FIFO decides which input pin feeds each FIFO, whether the entry is live, and whether the left and right samples are exchanged on the way. One pin may feed several FIFOs at once, so a single stereo input can fill all four FIFOs. FIFO 0 also carries a request for automatic down-sampling to basic audio, which is handed to a downstream converter.

The table is programmed one entry per write through an 8-bit configuration word. The block enforces contiguous filling: a FIFO may be switched on only when every lower-numbered FIFO is already on. A write that breaks this rule is dropped and a sticky error flag is raised. Any entry can be read back through a select input.

Top module: `sdmap_router`

## Requirements
- R1: After reset every entry is disabled with source 0, no swap and no down-sample request; no FIFO strobe is active, `map_err` and `ds_req` are 0, and read-back of FIFO f returns f in bits [1:0] and 0 elsewhere.
- R2: A write uses these fields of `cfg_wdata`: [1:0] target FIFO, [2] swap, [3] down-sample request, [5:4] source pin (0 to 3), [7] enable, [6] unused. An accepted write changes the target entry from the next cycle on, and read-back of that FIFO returns the written word with bit 6 cleared and bits [1:0] equal to the FIFO number.
- R3: When pin p has its valid bit high in a cycle, every enabled FIFO whose source is p shows `fifo_we` high in the following cycle, with its 48-bit slot of `fifo_wdata` holding the left sample in the upper 24 bits and the right sample in the lower 24 bits.
- R4: Several FIFOs mapped to the same pin all strobe in the same cycle with that pin's pair.
- R5: An enabled entry with swap set presents the right sample in the upper half and the left sample in the lower half.
- R6: A FIFO whose entry is disabled, or whose source pin has no valid strobe, shows no write strobe.
- R7: A write with enable set to FIFO n while any FIFO below n is disabled is dropped: the entry keeps its value and `map_err` is 1 from the next cycle.
- R8: `map_err` stays 1 once set and returns to 0 only through reset.
- R9: The down-sample bit is kept for FIFO 0 only; `ds_req` equals enable AND down-sample of entry 0, and for FIFOs 1 to 3 the bit reads back as 0 and has no effect on `ds_req`.
- R10: A write with enable clear is always accepted, and a write with enable set to FIFO 0 is always accepted.
- R11: A sample strobe in the same cycle as a mapping write is routed with the mapping that held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Mapping write strobe |
| cfg_wdata | input | 8 | Mapping write word |
| cfg_rsel | input | 2 | FIFO entry selected for read-back |
| cfg_rdata | output | 8 | Read-back of the selected entry |
| pin_valid | input | 4 | Per-pin stereo pair valid |
| pin_left | input | 96 | Left samples, pin p in bits [24p+23:24p] |
| pin_right | input | 96 | Right samples, pin p in bits [24p+23:24p] |
| fifo_we | output | 4 | Per-FIFO write strobe |
| fifo_wdata | output | 192 | Per-FIFO stereo pair, FIFO f in bits [48f+47:48f] |
| map_err | output | 1 | Sticky contiguity error |
| ds_req | output | 1 | Down-sample request from FIFO 0 entry |

## Verification
The assertions take for granted that a pin's samples are meaningful only in cycles where its valid bit is high, that configuration writes are single-cycle strobes sampled on the rising edge, and that reset is held for at least one edge before use. The stimulus changes every input on the falling edge only, issues at most one mapping write per cycle, fills samples with fresh random values tagged by pin number, and mixes directed table sequences (gap attempts, disables, a write coinciding with a sample) with a random phase whose writes may break the fill order on purpose.

// File: rtl/sdmap_pkg.sv
package sdmap_pkg;

   localparam int CFG_W    = 8;
   localparam int SEL_W    = 2;
   localparam int EN_POS   = 7;
   localparam int RSV_POS  = 6;
   localparam int SRC_LSB  = 4;
   localparam int DS_POS   = 3;
   localparam int SWAP_POS = 2;
   localparam int MAX_LANES = 1 << SEL_W;

   typedef struct packed {
      logic             en;
      logic [SEL_W-1:0] src;
      logic             ds;
      logic             swap;
   } map_entry_t;

   function automatic map_entry_t decode_entry(input logic [CFG_W-1:0] w);
      map_entry_t e;
      e.en   = w[EN_POS];
      e.src  = w[SRC_LSB +: SEL_W];
      e.ds   = w[DS_POS];
      e.swap = w[SWAP_POS];
      return e;
   endfunction

   function automatic logic [CFG_W-1:0] encode_entry(input map_entry_t e,
                                                     input logic [SEL_W-1:0] idx);
      logic [CFG_W-1:0] r;
      r                   = '0;
      r[EN_POS]           = e.en;
      r[SRC_LSB +: SEL_W] = e.src;
      r[DS_POS]           = e.ds;
      r[SWAP_POS]         = e.swap;
      r[SEL_W-1:0]        = idx;
      return r;
   endfunction

endpackage

// File: rtl/sdmap_cfg.sv
module sdmap_cfg
   import sdmap_pkg::*;
#(
   parameter int NUM_FIFOS = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [CFG_W-1:0]                cfg_wdata,
   input  logic [SEL_W-1:0]                cfg_rsel,
   output logic [CFG_W-1:0]                cfg_rdata,
   output map_entry_t [NUM_FIFOS-1:0]      tbl_o,
   output logic                            err_o,
   output logic                            ds_o
);

   map_entry_t [NUM_FIFOS-1:0] tbl_q;
   map_entry_t                 new_entry;
   logic [SEL_W-1:0]           tgt;
   logic                       tgt_in_range;
   logic                       lower_all_en;
   logic                       gap_hit;
   logic                       accept;
   logic                       err_q;
   logic                       unused_rsv;

   assign tgt        = cfg_wdata[SEL_W-1:0];
   assign new_entry  = decode_entry(cfg_wdata);
   assign unused_rsv = cfg_wdata[RSV_POS];

   // contiguity: every FIFO below the target must already be live
   always_comb begin
      lower_all_en = 1'b1;
      for (int i = 0; i < NUM_FIFOS; i++) begin
         if (i < int'(tgt) && !tbl_q[i].en) lower_all_en = 1'b0;
      end
   end

   assign tgt_in_range = int'(tgt) < NUM_FIFOS;
   assign gap_hit      = cfg_we & tgt_in_range & cfg_wdata[EN_POS] & ~lower_all_en;
   assign accept       = cfg_we & tgt_in_range & ~gap_hit;

   for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_entry
      map_entry_t entry_w;

      if (g == 0) begin : g_ds_kept
         assign entry_w = new_entry;
      end else begin : g_ds_dropped
         always_comb begin
            entry_w    = new_entry;
            entry_w.ds = 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) tbl_q[g] <= '0;
         else if (accept && tgt == SEL_W'(g)) tbl_q[g] <= entry_w;
      end

      assert_gap_keeps_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (gap_hit && tgt == SEL_W'(g)) |=> $stable(tbl_q[g]))
         else $error("rejected write changed entry %0d", g);

      assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (accept && tgt == SEL_W'(g)) |=>
            (tbl_q[g].en == $past(cfg_wdata[EN_POS]) &&
             tbl_q[g].src == $past(cfg_wdata[SRC_LSB +: SEL_W])))
         else $error("accepted write not stored in entry %0d", g);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (gap_hit) err_q <= 1'b1;
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_FIFOS; i++) begin
         if (cfg_rsel == SEL_W'(i)) cfg_rdata = encode_entry(tbl_q[i], SEL_W'(i));
      end
   end

   assign tbl_o = tbl_q;
   assign err_o = err_q;
   assign ds_o  = tbl_q[0].en & tbl_q[0].ds;

   assert_gap_sets_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gap_hit |=> err_q)
      else $error("gap write did not raise error");

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q)
      else $error("error flag cleared without reset");

endmodule

// File: rtl/sdmap_route.sv
module sdmap_route
   import sdmap_pkg::*;
#(
   parameter int NUM_PINS  = 4,
   parameter int SAMPLE_W  = 24,
   parameter bit HOLD_DATA = 1'b1,
   localparam int PAIR_W   = 2 * SAMPLE_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  map_entry_t                         entry_i,
   input  logic [NUM_PINS-1:0]                pin_valid_i,
   input  logic [NUM_PINS-1:0][SAMPLE_W-1:0]  pin_left_i,
   input  logic [NUM_PINS-1:0][SAMPLE_W-1:0]  pin_right_i,
   output logic                               we_o,
   output logic [PAIR_W-1:0]                  data_o
);

   logic                sel_v;
   logic [SAMPLE_W-1:0] sel_l;
   logic [SAMPLE_W-1:0] sel_r;
   logic [PAIR_W-1:0]   pair;
   logic                fire;
   logic                we_q;
   logic [PAIR_W-1:0]   data_q;

   always_comb begin
      sel_v = 1'b0;
      sel_l = '0;
      sel_r = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (entry_i.src == SEL_W'(p)) begin
            sel_v = pin_valid_i[p];
            sel_l = pin_left_i[p];
            sel_r = pin_right_i[p];
         end
      end
   end

   assign pair = entry_i.swap ? {sel_r, sel_l} : {sel_l, sel_r};
   assign fire = entry_i.en & sel_v;

   always_ff @(posedge clk) begin
      if (!rst_n) we_q <= 1'b0;
      else        we_q <= fire;
   end

   if (HOLD_DATA) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)    data_q <= '0;
         else if (fire) data_q <= pair;
      end
   end else begin : g_free
      always_ff @(posedge clk) begin
         if (!rst_n) data_q <= '0;
         else        data_q <= pair;
      end
   end

   assign we_o   = we_q;
   assign data_o = data_q;

   assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !entry_i.en |=> !we_o)
      else $error("strobe from disabled entry");

   assert_strobe_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |-> $past(|pin_valid_i))
      else $error("strobe without any pin valid");

endmodule

// File: rtl/sdmap_router.sv
module sdmap_router
   import sdmap_pkg::*;
#(
   parameter int NUM_PINS  = 4,
   parameter int NUM_FIFOS = 4,
   parameter int SAMPLE_W  = 24,
   parameter bit HOLD_DATA = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cfg_we,
   input  logic [7:0]                        cfg_wdata,
   input  logic [1:0]                        cfg_rsel,
   output logic [7:0]                        cfg_rdata,
   input  logic [NUM_PINS-1:0]               pin_valid,
   input  logic [NUM_PINS*SAMPLE_W-1:0]      pin_left,
   input  logic [NUM_PINS*SAMPLE_W-1:0]      pin_right,
   output logic [NUM_FIFOS-1:0]              fifo_we,
   output logic [NUM_FIFOS*2*SAMPLE_W-1:0]   fifo_wdata,
   output logic                              map_err,
   output logic                              ds_req
);

   localparam int PAIR_W = 2 * SAMPLE_W;

   initial begin
      assert (NUM_PINS >= 1 && NUM_PINS <= MAX_LANES)
         else $error("NUM_PINS out of range");
      assert (NUM_FIFOS >= 1 && NUM_FIFOS <= MAX_LANES)
         else $error("NUM_FIFOS out of range");
      assert (SAMPLE_W >= 1)
         else $error("SAMPLE_W must be positive");
   end

   map_entry_t [NUM_FIFOS-1:0]            tbl;
   logic [NUM_PINS-1:0][SAMPLE_W-1:0]     left_2d;
   logic [NUM_PINS-1:0][SAMPLE_W-1:0]     right_2d;

   assign left_2d  = pin_left;
   assign right_2d = pin_right;

   sdmap_cfg #(
      .NUM_FIFOS (NUM_FIFOS)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rsel  (cfg_rsel),
      .cfg_rdata (cfg_rdata),
      .tbl_o     (tbl),
      .err_o     (map_err),
      .ds_o      (ds_req)
   );

   for (genvar f = 0; f < NUM_FIFOS; f++) begin : g_lane
      sdmap_route #(
         .NUM_PINS  (NUM_PINS),
         .SAMPLE_W  (SAMPLE_W),
         .HOLD_DATA (HOLD_DATA)
      ) u_route (
         .clk         (clk),
         .rst_n       (rst_n),
         .entry_i     (tbl[f]),
         .pin_valid_i (pin_valid),
         .pin_left_i  (left_2d),
         .pin_right_i (right_2d),
         .we_o        (fifo_we[f]),
         .data_o      (fifo_wdata[f*PAIR_W +: PAIR_W])
      );
   end

   assert_ds_from_fifo0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ds_req |-> (cfg_rsel != 2'd0 || (cfg_rdata[7] && cfg_rdata[3])))
      else $error("down-sample request without live FIFO 0 entry");

endmodule

// File: tb/sdmap_router_tb.sv
module sdmap_router_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 24;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic [1:0]    cfg_rsel = '0;
   logic [7:0]    cfg_rdata;
   logic [3:0]    pin_valid = '0;
   logic [4*W-1:0] pin_left = '0;
   logic [4*W-1:0] pin_right = '0;
   logic [3:0]    fifo_we;
   logic [4*PW-1:0] fifo_wdata;
   logic          map_err;
   logic          ds_req;

   sdmap_router u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata), .pin_valid(pin_valid),
      .pin_left(pin_left), .pin_right(pin_right), .fifo_we(fifo_we),
      .fifo_wdata(fifo_wdata), .map_err(map_err), .ds_req(ds_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int          cyc;
      int          fifo;
      logic [PW-1:0] data;
      string       req;
   } exp_t;

   exp_t  sb_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc_cnt = 0;
   bit    mon_on = 1'b0;
   bit    done = 1'b0;
   string phase_req = "R6";

   // bench model of the mapping table, built from the requirements
   bit       m_en [4];
   bit [1:0] m_src [4];
   bit       m_swap [4];
   bit       m_ds0;
   bit       m_err;

   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   function automatic void fail(string req, logic [63:0] act, logic [63:0] exp);
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
   endfunction

   function automatic void chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) fail(req, act, exp);
   endfunction

   function automatic void model_reset();
      for (int f = 0; f < 4; f++) begin
         m_en[f] = 0; m_src[f] = 0; m_swap[f] = 0;
      end
      m_ds0 = 0;
      m_err = 0;
   endfunction

   function automatic void model_write(logic [7:0] wd);
      int  t;
      bit  gap;
      t   = int'(wd[1:0]);
      gap = 0;
      for (int i = 0; i < t; i++) if (!m_en[i]) gap = 1;
      if (wd[7] && gap) m_err = 1;
      else begin
         m_en[t]   = wd[7];
         m_src[t]  = wd[5:4];
         m_swap[t] = wd[2];
         if (t == 0) m_ds0 = wd[3];
      end
   endfunction

   function automatic logic [7:0] exp_rd(int f);
      return {m_en[f], 1'b0, m_src[f], (f == 0) ? m_ds0 : 1'b0, m_swap[f], 2'(f)};
   endfunction

   // driver: one cycle of stimulus; pushes the strobes it expects next cycle
   task automatic step(input bit we, input logic [7:0] wd, input logic [3:0] vmask);
      logic [3:0][W-1:0] l;
      logic [3:0][W-1:0] r;
      for (int p = 0; p < 4; p++) begin
         l[p] = {8'(p), 16'($urandom)};
         r[p] = {8'(8'h80 | p), 16'($urandom)};
      end
      cfg_we    = we;
      cfg_wdata = wd;
      pin_valid = vmask;
      pin_left  = l;
      pin_right = r;
      for (int f = 0; f < 4; f++) begin
         if (m_en[f] && vmask[m_src[f]]) begin
            exp_t e;
            int   share;
            share = 0;
            for (int g = 0; g < 4; g++) if (m_en[g] && m_src[g] == m_src[f]) share++;
            e.cyc  = cyc_cnt + 1;
            e.fifo = f;
            e.data = m_swap[f] ? {r[m_src[f]], l[m_src[f]]} : {l[m_src[f]], r[m_src[f]]};
            e.req  = m_swap[f] ? "R5" : (share > 1) ? "R4" : "R3";
            sb_q.push_back(e);
         end
      end
      if (we) model_write(wd);   // R11: the write takes effect after this cycle
      @(negedge clk);
      cfg_we    = 1'b0;
      pin_valid = '0;
   endtask

   task automatic check_state(input string req);
      for (int f = 0; f < 4; f++) begin
         cfg_rsel = 2'(f);
         #1;
         chk(req, cfg_rdata, exp_rd(f));
      end
      chk(req, map_err, m_err);
      chk(req, ds_req, m_en[0] & m_ds0);
      @(negedge clk);
   endtask

   // monitor: compares strobes and data against the scoreboard
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         for (int f = 0; f < 4; f++) begin
            bit hit;
            hit = (sb_q.size() > 0) && (sb_q[0].cyc == cyc_cnt) && (sb_q[0].fifo == f);
            n_chk++;
            if (hit) begin
               if (!fifo_we[f] || fifo_wdata[f*PW +: PW] !== sb_q[0].data)
                  fail(sb_q[0].req, {fifo_we[f], fifo_wdata[f*PW +: PW]}, {1'b1, sb_q[0].data});
               void'(sb_q.pop_front());
            end else if (fifo_we[f]) begin
               fail(phase_req, {60'(f), fifo_we[f]}, {60'(f), 1'b0});
            end
         end
         while (sb_q.size() > 0 && sb_q[0].cyc <= cyc_cnt) begin
            fail(sb_q[0].req, 0, {1'b1, sb_q[0].data});
            void'(sb_q.pop_front());
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc_cnt, 0);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;

      // R1: reset state
      chk("R1", fifo_we, 4'h0);
      chk("R1", map_err, 1'b0);
      chk("R1", ds_req, 1'b0);
      check_state("R1");

      // R2, R9: FIFO 0 from pin 2 with down-sample
      step(1, 8'hA8, 4'h0);
      cfg_rsel = 2'd0; #1;
      chk("R2", cfg_rdata, 8'hA8);
      chk("R9", ds_req, 1'b1);
      @(negedge clk);

      // R3: single mapping, all pins valid
      step(0, 8'h00, 4'hF);
      step(0, 8'h00, 4'h4);

      // R7: enable FIFO 2 while FIFO 1 is off
      step(1, 8'h82, 4'h0);
      chk("R7", map_err, 1'b1);
      cfg_rsel = 2'd2; #1;
      chk("R7", cfg_rdata, 8'h02);
      @(negedge clk);

      // R9: down-sample bit on FIFO 1 reads back clear
      step(1, 8'hAD, 4'h0);
      cfg_rsel = 2'd1; #1;
      chk("R9", cfg_rdata, 8'hA5);
      chk("R9", ds_req, 1'b1);
      @(negedge clk);

      step(1, 8'hA2, 4'h0);
      step(1, 8'h87, 4'h0);
      check_state("R2");

      // R4 shared pin 2 (FIFOs 0..2, FIFO 1 swapped R5); R5 pin 0 to FIFO 3
      step(0, 8'h00, 4'h4);
      step(0, 8'h00, 4'h1);
      phase_req = "R6";
      step(0, 8'h00, 4'h2);
      step(0, 8'h00, 4'hF);

      // R10: disable FIFO 1 is accepted although FIFO 2 stays on
      step(1, 8'h21, 4'h0);
      cfg_rsel = 2'd1; #1;
      chk("R10", cfg_rdata, 8'h21);
      @(negedge clk);
      step(0, 8'h00, 4'h4);

      // R11: enable FIFO 1 from pin 1 in the same cycle pin 1 is valid
      phase_req = "R11";
      step(1, 8'h91, 4'h2);
      step(0, 8'h00, 4'h2);
      phase_req = "R6";

      // R8: error still set; R10: FIFO 0 rewrite with enable always accepted
      chk("R8", map_err, 1'b1);
      step(1, 8'h9C, 4'h0);
      check_state("R10");
      step(1, 8'h28, 4'h0);
      chk("R9", ds_req, 1'b0);
      check_state("R9");

      // random phase
      for (int k = 0; k < 400; k++) begin
         bit we_r;
         we_r = ($urandom % 4) == 0;
         step(we_r, 8'($urandom), 4'($urandom));
         if (k % 50 == 49) check_state("R2");
      end
      check_state("R8");

      // second reset: clears error and table
      step(0, 8'h00, 4'h0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", map_err, 1'b0);
      chk("R1", fifo_we, 4'h0);
      check_state("R1");
      step(0, 8'h00, 4'hF);

      chk("R3", sb_q.size(), 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule